// File: doc/BRIEF.md
# DMA Channel Termination Sequencer

This block governs how one DMA channel finishes its work. It is loaded with a transfer count when the channel starts, and it decrements that count once for every completed transfer. It detects the transfer that brings the count to zero, which is the terminal count. A single direction bit sets the role of a shared termination pin. With the bit at 1, the block drives a one-cycle terminal-count pulse and enables the pin driver. With the bit at 0, the pin is an input, and an end-of-transfer request seen on it ends the channel at the close of the current transfer.

The block also spaces accesses on the peripheral bus. When the peripheral acknowledge is released during a peripheral-mode transfer, it holds the bus-available flag low for a programmable gap of 0 to 7 clock cycles. A configuration checker flags bit combinations that are not allowed. A start request made under such a combination is refused.

The shared pin appears at the ports as three separate signals: an input, an output and an output enable. Data movement and channel arbitration are handled elsewhere.

Top module: `dma_term_seq`

## Requirements
- R1: `cfg_err` is 1 one cycle after `cfg_tc_stop`=1 is presented with `cfg_dir`=0.
- R2: `cfg_err` is 1 one cycle after `cfg_sw_m2m`=1 is presented with `cfg_dir`=0. It is 0 one cycle after a legal combination is presented.
- R3: A `start` presented under an illegal combination leaves an idle channel inactive. A legal `start` sets `active` in the following cycle.
- R4: Each `xfer_done` while active decrements the count loaded from `start_count`. When `cfg_dir`=1, the `xfer_done` that takes the count from 1 to 0 raises `tc_out` for exactly one cycle, in the cycle after that strobe.
- R5: With `cfg_tc_stop`=1, `active` falls in the same cycle that the terminal-count pulse appears.
- R6: With `cfg_tc_stop`=0, the channel stays active through terminal count and keeps accepting transfers. No further pulse occurs until the count has wrapped all the way around.
- R7: `tc_oe` follows `cfg_dir` with one cycle of delay. `tc_out` is never 1 while `tc_oe` is 0, so terminal count produces no pulse when `cfg_dir`=0.
- R8: With `cfg_dir`=0, an `eot_in` pulse seen while active does not stop the channel by itself. `active` falls after the next `xfer_done`, including an `xfer_done` in the same cycle as `eot_in`.
- R9: `bus_avail` is 0 in the cycle after `ack` is sampled at 1.
- R10: With `cfg_periph_mode`=1 and hold value H, `bus_avail` stays 0 for exactly H cycles after the first clock edge that samples `ack` at 0, then returns to 1. For H=0 it returns at that first edge.
- R11: With `cfg_periph_mode`=0, `bus_avail` returns to 1 at the first edge that samples `ack` released, whatever the hold value.
- R12: During and after a synchronous reset, `active`, `tc_out`, `tc_oe` and `cfg_err` are 0 and `bus_avail` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dir | input | 1 | Pin role: 1 terminal-count output, 0 end-of-transfer input |
| cfg_tc_stop | input | 1 | Stop the channel at terminal count |
| cfg_sw_m2m | input | 1 | Channel runs software-initiated memory-to-memory transfers |
| cfg_periph_mode | input | 1 | Peripheral-mode transfer; enables the hold gap |
| cfg_hold | input | HOLD_W | Hold gap in clock cycles after the acknowledge is released |
| start | input | 1 | Load the count and activate the channel |
| start_count | input | CNT_W | Number of transfers to load |
| xfer_done | input | 1 | One-cycle strobe per completed transfer |
| ack | input | 1 | Peripheral acknowledge, active high |
| eot_in | input | 1 | End-of-transfer request from the shared pin |
| active | output | 1 | Channel is running |
| tc_out | output | 1 | Terminal-count pulse to the shared pin |
| tc_oe | output | 1 | Output enable for the shared pin |
| bus_avail | output | 1 | Peripheral bus free for the next access |
| cfg_err | output | 1 | Configuration bits are inconsistent |

## Verification
The assertions assume that `xfer_done` is a strobe and that the configuration bits are static while a channel runs. The pulse-width property further assumes CNT_W of at least 2, so the count cannot wrap straight back to 1. The bench changes configuration only while the channel is idle or across a reset. It raises `xfer_done` for single cycles and starts a channel only when it is idle. The acknowledge is held for several cycles and released cleanly, so each release is one falling edge.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;
  localparam int DEF_CNT_W  = 16;
  localparam int DEF_HOLD_W = 3;

  // Illegal settings: stop-on-count or software memory copy require output role
  function automatic logic cfg_illegal(input logic dir, input logic tc_stop,
                                       input logic sw_m2m);
    return !dir && (tc_stop || sw_m2m);
  endfunction
endpackage

// File: rtl/dma_term_cfgchk.sv
module dma_term_cfgchk
  import dma_term_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dir,
  input  logic tc_stop,
  input  logic sw_m2m,
  output logic bad_now,
  output logic err_q
);
  assign bad_now = cfg_illegal(dir, tc_stop, sw_m2m);

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= bad_now;
  end
endmodule

// File: rtl/dma_term_counter.sv
module dma_term_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir,
  input  logic             tc_stop,
  input  logic             cfg_bad,
  input  logic             start,
  input  logic [CNT_W-1:0] start_count,
  input  logic             xfer_done,
  input  logic             eot_in,
  output logic             active,
  output logic             tc_pulse,
  output logic             pin_oe
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] remain;
  logic             eot_seen;
  logic             is_last;

  assign is_last = (remain == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      remain   <= '0;
      active   <= 1'b0;
      tc_pulse <= 1'b0;
      eot_seen <= 1'b0;
      pin_oe   <= 1'b0;
    end else begin
      pin_oe   <= dir;
      tc_pulse <= 1'b0;
      if (start && !cfg_bad) begin
        remain   <= start_count;
        active   <= 1'b1;
        eot_seen <= 1'b0;
      end else if (active) begin
        if (!dir && eot_in) eot_seen <= 1'b1;
        if (xfer_done) begin
          remain <= remain - LAST;
          if (is_last) begin
            tc_pulse <= dir;
            if (tc_stop) active <= 1'b0;
          end
          if (!dir && (eot_seen || eot_in)) begin
            active   <= 1'b0;
            eot_seen <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_term_hold.sv
module dma_term_hold #(
  parameter int HOLD_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  logic              periph,
  input  logic [HOLD_W-1:0] hold,
  output logic              avail
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic              ack_q;
  logic [HOLD_W-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      gap   <= '0;
      avail <= 1'b1;
    end else begin
      ack_q <= ack;
      if (ack) begin
        avail <= 1'b0;
        gap   <= '0;
      end else if (ack_q) begin
        if (periph && hold != '0) begin
          gap   <= hold;
          avail <= 1'b0;
        end else begin
          gap   <= '0;
          avail <= 1'b1;
        end
      end else if (gap != '0) begin
        gap <= gap - ONE;
        if (gap == ONE) avail <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_term_seq.sv
module dma_term_seq
  import dma_term_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int HOLD_W = DEF_HOLD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_dir,
  input  logic              cfg_tc_stop,
  input  logic              cfg_sw_m2m,
  input  logic              cfg_periph_mode,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_count,
  input  logic              xfer_done,
  input  logic              ack,
  input  logic              eot_in,
  output logic              active,
  output logic              tc_out,
  output logic              tc_oe,
  output logic              bus_avail,
  output logic              cfg_err
);
  logic bad_now;

  dma_term_cfgchk u_cfgchk (
    .clk(clk), .rst(rst), .dir(cfg_dir), .tc_stop(cfg_tc_stop),
    .sw_m2m(cfg_sw_m2m), .bad_now(bad_now), .err_q(cfg_err)
  );

  dma_term_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .dir(cfg_dir), .tc_stop(cfg_tc_stop),
    .cfg_bad(bad_now), .start(start), .start_count(start_count),
    .xfer_done(xfer_done), .eot_in(eot_in), .active(active),
    .tc_pulse(tc_out), .pin_oe(tc_oe)
  );

  dma_term_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .ack(ack), .periph(cfg_periph_mode),
    .hold(cfg_hold), .avail(bus_avail)
  );
endmodule

// File: rtl/dma_term_seq_chk.sv
module dma_term_seq_chk #(
  parameter int HOLD_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_dir,
  input logic              cfg_tc_stop,
  input logic              cfg_sw_m2m,
  input logic              cfg_periph_mode,
  input logic [HOLD_W-1:0] cfg_hold,
  input logic              start,
  input logic              ack,
  input logic              active,
  input logic              tc_out,
  input logic              tc_oe,
  input logic              bus_avail,
  input logic              cfg_err
);
  p_stop_err_r1: assert property (@(posedge clk) disable iff (rst)
    (cfg_tc_stop && !cfg_dir) |=> cfg_err);

  p_m2m_err_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_sw_m2m && !cfg_dir) |=> cfg_err);

  p_refuse_start_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !active && !cfg_dir && (cfg_tc_stop || cfg_sw_m2m)) |=> !active);

  p_tc_single_r4: assert property (@(posedge clk) disable iff (rst)
    tc_out |=> !tc_out);

  p_tc_halts_r5: assert property (@(posedge clk) disable iff (rst)
    (tc_out && $past(cfg_tc_stop)) |-> !active);

  p_tc_needs_oe_r7: assert property (@(posedge clk) disable iff (rst)
    tc_out |-> tc_oe);

  p_ack_busy_r9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !bus_avail);

  p_gap_starts_r10: assert property (@(posedge clk) disable iff (rst)
    ($fell(ack) && cfg_periph_mode && cfg_hold != '0) |=> !bus_avail);

  p_no_gap_r11: assert property (@(posedge clk) disable iff (rst)
    ($fell(ack) && (!cfg_periph_mode || cfg_hold == '0)) |=> bus_avail);
endmodule

bind dma_term_seq dma_term_seq_chk #(.HOLD_W(HOLD_W)) u_chk (.*);

// File: tb/dma_term_seq_bench.sv
module dma_term_seq_bench;
  localparam int CNT_W  = 16;
  localparam int HOLD_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_dir = 1'b0, cfg_tc_stop = 1'b0, cfg_sw_m2m = 1'b0, cfg_periph_mode = 1'b0;
  logic [HOLD_W-1:0] cfg_hold = '0;
  logic start = 1'b0;
  logic [CNT_W-1:0] start_count = '0;
  logic xfer_done = 1'b0, ack = 1'b0, eot_in = 1'b0;
  logic active, tc_out, tc_oe, bus_avail, cfg_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  dma_term_seq #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_dma_term_seq (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; start = 1'b0; xfer_done = 1'b0; ack = 1'b0; eot_in = 1'b0;
    cfg_dir = 1'b0; cfg_tc_stop = 1'b0; cfg_sw_m2m = 1'b0;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic done_once();
    xfer_done = 1'b1;
    step();
    xfer_done = 1'b0;
  endtask

  task automatic start_chan(input int n);
    start_count = CNT_W'(n);
    start = 1'b1;
    step();
    start = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    check("R12 active", active, 0);
    check("R12 tc_out", tc_out, 0);
    check("R12 tc_oe", tc_oe, 0);
    check("R12 cfg_err", cfg_err, 0);
    check("R12 bus_avail", bus_avail, 1);
    rst = 1'b0;
    step();
    check("R12 active after release", active, 0);
    check("R12 bus_avail after release", bus_avail, 1);
  endtask

  task automatic t_config();
    do_reset();
    cfg_dir = 1'b0; cfg_tc_stop = 1'b1; cfg_sw_m2m = 1'b0;
    step();
    check("R1 stop without output role", cfg_err, 1);
    cfg_tc_stop = 1'b0; cfg_sw_m2m = 1'b1;
    step();
    check("R2 m2m without output role", cfg_err, 1);
    start_chan(4);
    check("R3 illegal start refused", active, 0);
    cfg_dir = 1'b1; cfg_tc_stop = 1'b1;
    step();
    check("R2 legal combination", cfg_err, 0);
    check("R7 oe follows dir", tc_oe, 1);
    start_chan(4);
    check("R3 legal start", active, 1);
  endtask

  task automatic t_tc_stop();
    do_reset();
    cfg_dir = 1'b1; cfg_tc_stop = 1'b1;
    step();
    start_chan(3);
    done_once();
    check("R4 no pulse at count 2", tc_out, 0);
    done_once();
    check("R4 no pulse at count 1", tc_out, 0);
    check("R5 still active", active, 1);
    done_once();
    check("R4 pulse on final transfer", tc_out, 1);
    check("R5 stops at terminal count", active, 0);
    step();
    check("R4 pulse lasts one cycle", tc_out, 0);
  endtask

  task automatic t_tc_run();
    do_reset();
    cfg_dir = 1'b1; cfg_tc_stop = 1'b0;
    step();
    start_chan(2);
    done_once();
    done_once();
    check("R4 pulse at count zero", tc_out, 1);
    check("R6 runs past terminal count", active, 1);
    for (int i = 0; i < 4; i++) begin
      done_once();
      check("R6 no pulse after wrap", tc_out, 0);
      check("R6 still active", active, 1);
    end
  endtask

  task automatic t_eot();
    do_reset();
    cfg_dir = 1'b0; cfg_tc_stop = 1'b0;
    step();
    check("R7 oe low for input role", tc_oe, 0);
    start_chan(10);
    eot_in = 1'b1;
    step();
    eot_in = 1'b0;
    step();
    check("R8 request alone keeps channel", active, 1);
    done_once();
    check("R8 stops after next transfer", active, 0);
    check("R8 no pulse", tc_out, 0);
    start_chan(10);
    eot_in = 1'b1; xfer_done = 1'b1;
    step();
    eot_in = 1'b0; xfer_done = 1'b0;
    check("R8 same-cycle request stops", active, 0);
    start_chan(1);
    done_once();
    check("R7 no pulse in input role", tc_out, 0);
    check("R7 input role keeps running", active, 1);
  endtask

  task automatic t_hold(input int h, input logic periph);
    int lows;
    cfg_periph_mode = periph;
    cfg_hold = HOLD_W'(h);
    ack = 1'b1;
    step();
    check("R9 busy during acknowledge", bus_avail, 0);
    step(); step();
    ack = 1'b0;
    lows = 0;
    for (int i = 0; i < 12; i++) begin
      step();
      if (bus_avail) break;
      lows++;
    end
    if (periph) check("R10 hold gap length", lows, h);
    else        check("R11 no gap outside peripheral mode", lows, 0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_config();
    t_tc_stop();
    t_tc_run();
    t_eot();
    do_reset();
    t_hold(0, 1'b1);
    t_hold(3, 1'b1);
    t_hold(7, 1'b1);
    t_hold(1, 1'b1);
    t_hold(5, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule